// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Responder

This block answers the processor's interrupt acknowledge (IACK) cycles. When the IACK strobe rises, it decodes which channel is being acknowledged and picks one of four answers. It can drive an internally generated vector, or fetch a vector byte from the local I/O bus after a timed access window. It can forward a vector byte delivered by a system-bus interrupter. It can also leave the CPU data bus alone and only pulse the matching local acknowledge line. A channel code it cannot decode is answered with a fixed empty vector, so the processor never waits into a bus timeout.

Each of the four local channels has a 2-bit answer mode taken from an 8-bit mode register. An internal vector takes its upper two bits from a separate vector page input and its low six bits from the channel's vector number. The two external-fetch access windows are counted in clock cycles. They are derived from the clock frequency parameter: 1000 ns for the slow mode and 500 ns for the fast mode, rounded up.

Top module: `iack_vector_responder`

## Requirements
- R1: After reset the vector output enable and the cycle acknowledge are low, the CPU vector bus reads 0, and all four local acknowledge lines are high.
- R2: Channel code 0 (mailbox) is answered one clock after IACK is seen, with output enable and acknowledge high and the vector {page[1:0], 6'h00}.
- R3: Local channels 4..7 use channel codes 8..11 (local index 0..3). In mode 00 they are answered one clock after IACK with the vector {page[1:0], 6'h34 + index}, and the matching local acknowledge line is low.
- R4: In mode 01 the matching local acknowledge line goes low one clock after IACK. The output enable and the cycle acknowledge stay low for the whole cycle.
- R5: In mode 10 the local acknowledge line goes low one clock after IACK. The cycle acknowledge rises exactly SLOW clocks after that (SLOW = ceil(1000 ns × CLK_MHZ / 1000)). The vector is the local I/O byte sampled on that edge, and it is held for the rest of the cycle.
- R6: Mode 11 behaves like mode 10, except that the window is FAST = ceil(500 ns × CLK_MHZ / 1000) clocks.
- R7: Mode register bits [2i+1:2i] select the mode of local index i. The other fields have no effect on that channel.
- R8: At most one local acknowledge line is low at any time. A line is low only while its own local channel is being acknowledged. It is never low for mailbox, system-bus or undecodable codes.
- R9: Channel codes 1..7 (system-bus levels) wait for the system-bus valid strobe with the cycle acknowledge low. On the first clock where valid is high, the system-bus byte is captured unchanged, without the page bits. Output enable and acknowledge follow on the next clock.
- R10: Channel codes 12..15 are undecodable. They are answered one clock after IACK with the vector 8'h3F, with output enable and acknowledge high.
- R11: One clock after IACK falls, the output enable, the cycle acknowledge and every local acknowledge line are inactive. A fetch or wait in progress is abandoned, and the next IACK is decoded afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iack_i | input | 1 | IACK strobe, held high for the whole cycle |
| chan_i | input | CHAN_W | Acknowledged channel code |
| mode_reg_i | input | 2*N_LOCAL | Per-local-channel answer mode, 2 bits each |
| vec_page_i | input | 2 | Upper two bits of internal vectors |
| lio_data_i | input | 8 | Local I/O bus data byte |
| sys_vec_i | input | 8 | System-bus interrupter vector byte |
| sys_vec_valid_i | input | 1 | System-bus vector byte is valid |
| cpu_vec_o | output | 8 | Vector driven on the CPU data bus upper byte |
| cpu_vec_oe_o | output | 1 | Enable for cpu_vec_o |
| cpu_ack_o | output | 1 | Cycle acknowledge to the processor |
| local_ack_n_o | output | N_LOCAL | Active-low local acknowledge lines, bit i for local index i |

## Verification
The hardest situation to reach is the sampling instant at the end of an external fetch window. Nothing at the ports marks it, and a design sampling one clock early or late looks identical if the local bus byte is steady. The stimulus therefore holds the inverse of the good byte on the local bus for the whole window, switches to the good byte only just before the final edge, and then scrambles it again to confirm the captured value holds. The bench uses a reduced clock-frequency parameter, so both windows stay short. This lets every channel, every mode field position and every page value be swept. Each mode field is tried with differing values in its neighbouring fields, and one fetch is aborted mid-window.

// File: rtl/iackv_pkg.sv
package iackv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESP,
    ST_PASS,
    ST_FETCH,
    ST_WAIT_SYS
  } iackv_state_e;

  typedef enum logic [1:0] {
    CL_MBOX,
    CL_SYS,
    CL_LOCAL,
    CL_BAD
  } iackv_class_e;

  typedef enum logic [1:0] {
    MD_INTERNAL = 2'b00,
    MD_ACK_ONLY = 2'b01,
    MD_EXT_SLOW = 2'b10,
    MD_EXT_FAST = 2'b11
  } iackv_mode_e;

  // Clock cycles covering a window of ns nanoseconds, rounded up
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  // Internal vector: page bits on top, channel number below
  function automatic logic [7:0] make_vec(input logic [1:0] page,
                                          input logic [5:0] num);
    return {page, num};
  endfunction

  function automatic logic [5:0] local_num(input logic [5:0] base,
                                           input int unsigned idx);
    return base + 6'(idx);
  endfunction

endpackage

// File: rtl/iackv_decode.sv
module iackv_decode
  import iackv_pkg::*;
#(
  parameter int unsigned CHAN_W     = 4,
  parameter int unsigned N_LOCAL    = 4,
  parameter int unsigned MBOX_CODE  = 0,
  parameter int unsigned SYS_LEVELS = 7,
  parameter int unsigned LOCAL_BASE = 8,
  localparam int unsigned LIDX_W    = (N_LOCAL > 1) ? $clog2(N_LOCAL) : 1,
  localparam int unsigned MODE_W    = 2 * N_LOCAL
) (
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [MODE_W-1:0] mode_reg_i,
  output iackv_class_e      cls_o,
  output logic [LIDX_W-1:0] lidx_o,
  output iackv_mode_e       lmode_o
);

  logic [N_LOCAL-1:0] hit;
  logic [1:0]         field [N_LOCAL];

  genvar gi;
  generate
    for (gi = 0; gi < N_LOCAL; gi++) begin : g_local
      assign hit[gi]   = (32'(chan_i) == LOCAL_BASE + gi);
      assign field[gi] = mode_reg_i[2*gi +: 2];
    end
  endgenerate

  always_comb begin
    lidx_o  = '0;
    lmode_o = MD_INTERNAL;
    for (int i = 0; i < N_LOCAL; i++) begin
      if (hit[i]) begin
        lidx_o  = LIDX_W'(i);
        lmode_o = iackv_mode_e'(field[i]);
      end
    end
    if (32'(chan_i) == MBOX_CODE)
      cls_o = CL_MBOX;
    else if (32'(chan_i) >= 1 && 32'(chan_i) <= SYS_LEVELS)
      cls_o = CL_SYS;
    else if (|hit)
      cls_o = CL_LOCAL;
    else
      cls_o = CL_BAD;
  end

endmodule

// File: rtl/iackv_timer.sv
module iackv_timer #(
  parameter int unsigned SLOW_CYC = 200,
  parameter int unsigned FAST_CYC = 100,
  localparam int unsigned MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC,
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fast_i,
  input  logic abort_i,
  output logic done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             run_q;
  logic             at_end;

  assign at_end = (cnt_q == lim_q - CNT_W'(1));
  assign done_o = run_q && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= CNT_W'(SLOW_CYC);
      run_q <= 1'b0;
    end else if (abort_i) begin
      run_q <= 1'b0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      lim_q <= fast_i ? CNT_W'(FAST_CYC) : CNT_W'(SLOW_CYC);
    end else if (run_q) begin
      if (at_end) run_q <= 1'b0;
      else        cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R5/R6: the counter never runs past its window
  p_cnt_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < lim_q));

  // R5/R6: the window ends right after done
  p_done_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !abort_i) |=> !run_q);

endmodule

// File: rtl/iack_vector_responder.sv
module iack_vector_responder
  import iackv_pkg::*;
#(
  parameter int unsigned CHAN_W         = 4,
  parameter int unsigned N_LOCAL        = 4,
  parameter int unsigned MBOX_CODE      = 0,
  parameter int unsigned SYS_LEVELS     = 7,
  parameter int unsigned LOCAL_BASE     = 8,
  parameter logic [5:0]  MBOX_NUM       = 6'h00,
  parameter logic [5:0]  LOCAL_NUM_BASE = 6'h34,
  parameter logic [7:0]  EMPTY_VEC      = 8'h3F,
  parameter int unsigned CLK_MHZ        = 200,
  parameter int unsigned SLOW_NS        = 1000,
  parameter int unsigned FAST_NS        = 500,
  localparam int unsigned MODE_W        = 2 * N_LOCAL,
  localparam int unsigned LIDX_W        = (N_LOCAL > 1) ? $clog2(N_LOCAL) : 1,
  localparam int unsigned SLOW_CYC      = ns_to_cycles(SLOW_NS, CLK_MHZ),
  localparam int unsigned FAST_CYC      = ns_to_cycles(FAST_NS, CLK_MHZ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iack_i,
  input  logic [CHAN_W-1:0]  chan_i,
  input  logic [MODE_W-1:0]  mode_reg_i,
  input  logic [1:0]         vec_page_i,
  input  logic [7:0]         lio_data_i,
  input  logic [7:0]         sys_vec_i,
  input  logic               sys_vec_valid_i,
  output logic [7:0]         cpu_vec_o,
  output logic               cpu_vec_oe_o,
  output logic               cpu_ack_o,
  output logic [N_LOCAL-1:0] local_ack_n_o
);

  iackv_class_e      d_cls;
  logic [LIDX_W-1:0] d_lidx;
  iackv_mode_e       d_mode;

  iackv_decode #(
    .CHAN_W    (CHAN_W),
    .N_LOCAL   (N_LOCAL),
    .MBOX_CODE (MBOX_CODE),
    .SYS_LEVELS(SYS_LEVELS),
    .LOCAL_BASE(LOCAL_BASE)
  ) u_decode (
    .chan_i    (chan_i),
    .mode_reg_i(mode_reg_i),
    .cls_o     (d_cls),
    .lidx_o    (d_lidx),
    .lmode_o   (d_mode)
  );

  iackv_state_e       state_q;
  iackv_class_e       cls_q;
  iackv_mode_e        lmode_q;
  logic [7:0]         vec_q;
  logic [N_LOCAL-1:0] hot_q;

  // Named events
  logic accept_evt;
  logic release_evt;
  logic fetch_start;
  logic fetch_done;
  logic sys_take;

  assign accept_evt  = (state_q == ST_IDLE) && iack_i;
  assign release_evt = (state_q != ST_IDLE) && !iack_i;
  assign fetch_start = accept_evt && (d_cls == CL_LOCAL) &&
                       ((d_mode == MD_EXT_SLOW) || (d_mode == MD_EXT_FAST));
  assign sys_take    = (state_q == ST_WAIT_SYS) && iack_i && sys_vec_valid_i;

  iackv_timer #(
    .SLOW_CYC(SLOW_CYC),
    .FAST_CYC(FAST_CYC)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(fetch_start),
    .fast_i (d_mode == MD_EXT_FAST),
    .abort_i(!iack_i),
    .done_o (fetch_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cls_q   <= CL_BAD;
      lmode_q <= MD_INTERNAL;
      vec_q   <= '0;
      hot_q   <= '0;
    end else if (release_evt) begin
      state_q <= ST_IDLE;
      hot_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (iack_i) begin
          cls_q   <= d_cls;
          lmode_q <= d_mode;
          unique case (d_cls)
            CL_MBOX: begin
              vec_q   <= make_vec(vec_page_i, MBOX_NUM);
              state_q <= ST_RESP;
            end
            CL_BAD: begin
              vec_q   <= EMPTY_VEC;
              state_q <= ST_RESP;
            end
            CL_SYS: state_q <= ST_WAIT_SYS;
            CL_LOCAL: begin
              hot_q <= N_LOCAL'(1) << d_lidx;
              unique case (d_mode)
                MD_INTERNAL: begin
                  vec_q   <= make_vec(vec_page_i,
                                      local_num(LOCAL_NUM_BASE, 32'(d_lidx)));
                  state_q <= ST_RESP;
                end
                MD_ACK_ONLY: state_q <= ST_PASS;
                default:     state_q <= ST_FETCH;
              endcase
            end
            default: state_q <= ST_IDLE;
          endcase
        end
        ST_FETCH: if (fetch_done) begin
          vec_q   <= lio_data_i;
          state_q <= ST_RESP;
        end
        ST_WAIT_SYS: if (sys_take) begin
          vec_q   <= sys_vec_i;
          state_q <= ST_RESP;
        end
        default: state_q <= state_q;
      endcase
    end
  end

  assign cpu_vec_oe_o  = (state_q == ST_RESP);
  assign cpu_ack_o     = (state_q == ST_RESP);
  assign cpu_vec_o     = cpu_vec_oe_o ? vec_q : 8'h00;
  assign local_ack_n_o = ~hot_q;

  // R8: never more than one local acknowledge line active
  p_one_lack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~local_ack_n_o));

  // R8: local acknowledge only for a local channel
  p_lack_own_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (local_ack_n_o != '1) |-> (cls_q == CL_LOCAL));

  // R11: everything inactive one clock after IACK falls
  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_i |=> (!cpu_vec_oe_o && !cpu_ack_o && (local_ack_n_o == '1)));

  // R4: acknowledge-only mode never completes the cycle itself
  p_pass_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls_q == CL_LOCAL) && (lmode_q == MD_ACK_ONLY)) |-> !cpu_ack_o);

  // R9: a system-bus answer follows the valid strobe
  p_sys_after_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_ack_o) && (cls_q == CL_SYS)) |-> $past(sys_vec_valid_i));

  // R10: undecodable channels get the empty vector
  p_empty_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack_o && (cls_q == CL_BAD)) |-> (cpu_vec_o == EMPTY_VEC));

  // R5: the answered vector holds while the cycle lasts
  p_vec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack_o && $past(cpu_ack_o)) |-> $stable(cpu_vec_o));

endmodule

// File: tb/sim_iack_vector_responder.sv
module sim_iack_vector_responder;

  localparam int unsigned MHZ  = 20;
  localparam int unsigned SLOW = (1000 * MHZ + 999) / 1000;
  localparam int unsigned FAST = (500 * MHZ + 999) / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iack = 1'b0;
  logic [3:0] chan = '0;
  logic [7:0] mode_reg = '0;
  logic [1:0] page = '0;
  logic [7:0] lio = '0;
  logic [7:0] sysv = '0;
  logic       sysval = 1'b0;
  logic [7:0] vec;
  logic       oe, ack;
  logic [3:0] lack_n;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  iack_vector_responder #(.CLK_MHZ(MHZ)) u0 (
    .clk(clk), .rst_n(rst_n), .iack_i(iack), .chan_i(chan),
    .mode_reg_i(mode_reg), .vec_page_i(page), .lio_data_i(lio),
    .sys_vec_i(sysv), .sys_vec_valid_i(sysval),
    .cpu_vec_o(vec), .cpu_vec_oe_o(oe), .cpu_ack_o(ack),
    .local_ack_n_o(lack_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic out_chk(input string tag, input bit e_oe, input bit e_ack,
                         input logic [7:0] e_vec, input logic [3:0] e_lack);
    chk({tag, " oe"}, oe, e_oe);
    chk({tag, " ack"}, ack, e_ack);
    if (e_oe) chk({tag, " vec"}, vec, e_vec);
    chk({tag, " lack_n"}, lack_n, e_lack);
  endtask

  task automatic begin_iack(input logic [3:0] c);
    chan = c;
    iack = 1'b1;
    step();
  endtask

  task automatic end_iack(input string tag);
    iack = 1'b0;
    step();
    out_chk({tag, " R11 release"}, 0, 0, 8'h00, 4'hF);
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    out_chk("R1 reset", 0, 0, 8'h00, 4'hF);
    chk("R1 reset vec", vec, 0);
    rst_n = 1'b1;
    step();

    // R2 mailbox and R10 undecodable, all pages
    for (int p = 0; p < 4; p++) begin
      page = 2'(p);
      begin_iack(4'd0);
      out_chk("R2 mailbox", 1, 1, {2'(p), 6'h00}, 4'hF);
      end_iack("R2");
      for (int c = 12; c < 16; c++) begin
        begin_iack(4'(c));
        out_chk("R10 empty", 1, 1, 8'h3F, 4'hF);
        end_iack("R10");
      end
    end

    // R9 system-bus levels
    page = 2'd3;
    for (int lv = 1; lv <= 7; lv++) begin
      sysv = 8'(8'h15 * lv);
      begin_iack(4'(lv));
      for (int d = 0; d < lv % 3 + 1; d++) begin
        out_chk("R9 wait", 0, 0, 8'h00, 4'hF);
        step();
      end
      sysval = 1'b1;
      step();
      sysval = 1'b0;
      sysv = 8'hEE;
      out_chk("R9 sys vec", 1, 1, 8'(8'h15 * lv), 4'hF);
      end_iack("R9");
    end

    // R3..R8 local channels, every mode in every field position
    for (int li = 0; li < 4; li++) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] mr;
        logic [3:0] el;
        logic [7:0] good;
        int win;
        for (int j = 0; j < 4; j++) mr[2*j +: 2] = 2'((m + 1 + j) % 4);
        mr[2*li +: 2] = 2'(m);
        mode_reg = mr;
        page = 2'(3 - li);
        el = ~(4'(1) << li);
        good = 8'(8'h5A + 8'h11 * li + m);
        lio = ~good;
        begin_iack(4'(8 + li));
        case (m)
          0: out_chk("R3 R7 internal", 1, 1, {2'(3 - li), 6'(6'h34 + li)}, el);
          1: begin
            for (int k = 0; k < 6; k++) begin
              out_chk("R4 ack-only", 0, 0, 8'h00, el);
              step();
            end
          end
          default: begin
            win = (m == 2) ? SLOW : FAST;
            out_chk("R5 R6 R8 fetch start", 0, 0, 8'h00, el);
            for (int k = 0; k < win - 1; k++) step();
            out_chk("R5 R6 fetch window end", 0, 0, 8'h00, el);
            lio = good;
            step();
            lio = ~good;
            out_chk("R5 R6 R7 fetched vec", 1, 1, good, el);
            step();
            out_chk("R5 vec held", 1, 1, good, el);
          end
        endcase
        end_iack("R8");
      end
    end

    // R11 abort a slow fetch mid-window, then a fresh cycle
    mode_reg = 8'b00_00_00_10;
    lio = 8'h99;
    begin_iack(4'd8);
    repeat (5) step();
    end_iack("R11 abort");
    repeat (SLOW) step();
    out_chk("R11 after abort", 0, 0, 8'h00, 4'hF);
    mode_reg = 8'h00;
    page = 2'd1;
    begin_iack(4'd8);
    out_chk("R11 fresh R3", 1, 1, 8'h74, 4'hE);
    end_iack("R11");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule